// File: doc/BRIEF.md
# Bidirectional One-Hot Ring Rotator

This block holds a single circulating 1 in a small register and moves it by one bit position on every rising clock edge. One control line picks the direction of travel. An active-high initialize line forces the register to the seed pattern, which has only the top bit set. The force acts at once and does not wait for a clock edge. It keeps acting for as long as the line stays high.

Each storage bit is its own flop, and each flop has one asynchronous force input. The top bit's flop forces to 1 and every other flop forces to 0, so the seed pattern appears while the clock is stopped. Rotation logic sits in a separate combinational stage. In that stage the direction value is an enumerated type with two states, ROT_LEFT (code 0) and ROT_RIGHT (code 1). There are two transitions, "rotate toward the low end" and "rotate toward the high end", and the direction sampled at the edge selects one of them. A typical use is a phase selector or a round-robin enable that a system controller can seed at any time.

Top module: `ring_rotator`

## Requirements
- R1: While `init_i` is 1, `ring_o` equals the seed pattern 1000 (bit 3 set, bits 2..0 clear). The pattern appears as soon as `init_i` rises, with no clock edge, and it holds through any clock edges while `init_i` stays high.
- R2: With `init_i` at 0 and `dir_right_i` at 1 on a rising edge, the register moves right. Each bit i takes the old bit i+1, and bit 3 takes the old bit 0.
- R3: With `init_i` at 0 and `dir_right_i` at 0 on a rising edge, the register moves left. Each bit i takes the old bit i-1, and bit 0 takes the old bit 3.
- R4: The direction used is the value of `dir_right_i` at the rising edge. Changes of `dir_right_i` between edges leave `ring_o` unchanged.
- R5: After release from the seed, four right moves give 0100, 0010, 0001 and then 1000.
- R6: After an initialize, exactly one bit of `ring_o` is 1 at every edge where `init_i` is 0.
- R7: After release from the seed, four left moves give 0001, 0010, 0100 and then 1000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; the rising edge moves the register |
| init_i | input | 1 | Asynchronous, active-high force to the seed pattern |
| dir_right_i | input | 1 | 1 moves the register right, 0 moves it left |
| ring_o | output | WIDTH (4) | Current register contents |

## Verification
The bench builds the block with the default width of four, so the seed is 1000. With four bits, a full lap in either direction takes only four edges. The stimulus table therefore covers complete laps both ways, mid-lap reversals and an initialize held across an edge. Directed steps then raise `init_i` between edges to show the force without a clock edge. They also wiggle `dir_right_i` between edges to show that only the value present at the edge counts.

// File: rtl/ring_pkg.sv
package ring_pkg;

    // Direction of travel; the code value matches the direction input pin.
    typedef enum logic {
        ROT_LEFT  = 1'b0,
        ROT_RIGHT = 1'b1
    } rot_dir_e;

    // Value a storage cell takes while the force line is high.
    typedef enum logic {
        CELL_FORCE_LOW  = 1'b0,
        CELL_FORCE_HIGH = 1'b1
    } cell_kind_e;

endpackage

// File: rtl/ring_step.sv
module ring_step
    import ring_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  rot_dir_e           dir_i,
    input  logic [WIDTH-1:0]   cur_i,
    output logic [WIDTH-1:0]   nxt_o
);

    always_comb begin
        unique case (dir_i)
            ROT_RIGHT: nxt_o = {cur_i[0], cur_i[WIDTH-1:1]};
            ROT_LEFT:  nxt_o = {cur_i[WIDTH-2:0], cur_i[WIDTH-1]};
            default:   nxt_o = cur_i;
        endcase
    end

endmodule

// File: rtl/ring_cell.sv
module ring_cell
    import ring_pkg::*;
#(
    parameter cell_kind_e KIND = CELL_FORCE_LOW
) (
    input  logic clk_i,
    input  logic force_i,
    input  logic d_i,
    output logic q_o
);

    generate
        if (KIND == CELL_FORCE_HIGH) begin : g_preset
            always_ff @(posedge clk_i or posedge force_i) begin
                if (force_i) q_o <= 1'b1;
                else         q_o <= d_i;
            end
        end else begin : g_clear
            always_ff @(posedge clk_i or posedge force_i) begin
                if (force_i) q_o <= 1'b0;
                else         q_o <= d_i;
            end
        end
    endgenerate

endmodule

// File: rtl/ring_rotator.sv
module ring_rotator
    import ring_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk_i,
    input  logic             init_i,
    input  logic             dir_right_i,
    output logic [WIDTH-1:0] ring_o
);

    localparam int TOP = WIDTH - 1;

    rot_dir_e         dir_sel;
    logic [WIDTH-1:0] ring_nxt;

    assign dir_sel = rot_dir_e'(dir_right_i);

    ring_step #(.WIDTH(WIDTH)) u_step (
        .dir_i (dir_sel),
        .cur_i (ring_o),
        .nxt_o (ring_nxt)
    );

    // One cell per bit: the top cell presets, all others clear.
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        localparam cell_kind_e KIND_I = (i == TOP) ? CELL_FORCE_HIGH : CELL_FORCE_LOW;
        ring_cell #(.KIND(KIND_I)) u_cell (
            .clk_i   (clk_i),
            .force_i (init_i),
            .d_i     (ring_nxt[i]),
            .q_o     (ring_o[i])
        );
    end

endmodule

// File: rtl/ring_rotator_chk.sv
module ring_rotator_chk #(
    parameter int WIDTH = 4
) (
    input logic             clk_i,
    input logic             init_i,
    input logic             dir_right_i,
    input logic [WIDTH-1:0] ring_o
);

    localparam logic [WIDTH-1:0] SEED = {1'b1, {(WIDTH-1){1'b0}}};

    AST_FORCE_SEED: assert property (@(posedge clk_i)
        init_i |-> ring_o == SEED); // R1

    AST_MOVE_RIGHT: assert property (@(posedge clk_i) disable iff (init_i)
        dir_right_i |=> ring_o == {$past(ring_o[0]), $past(ring_o[WIDTH-1:1])}); // R2

    AST_MOVE_LEFT: assert property (@(posedge clk_i) disable iff (init_i)
        !dir_right_i |=> ring_o == {$past(ring_o[WIDTH-2:0]), $past(ring_o[WIDTH-1])}); // R3

    AST_SINGLE_HOT: assert property (@(posedge clk_i) disable iff (init_i)
        $countones(ring_o) == 1); // R6

endmodule

bind ring_rotator ring_rotator_chk #(.WIDTH(WIDTH)) u_chk (
    .clk_i       (clk_i),
    .init_i      (init_i),
    .dir_right_i (dir_right_i),
    .ring_o      (ring_o)
);

// File: tb/ring_rotator_bench.sv
`timescale 1ns/1ps
module ring_rotator_bench;

    logic       clk = 1'b0;
    logic       init_i = 1'b0;
    logic       dir_right_i = 1'b0;
    logic [3:0] ring_o;
    int         n_checks = 0;
    int         n_fails = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    ring_rotator #(.WIDTH(4)) u_ring_rotator (
        .clk_i       (clk),
        .init_i      (init_i),
        .dir_right_i (dir_right_i),
        .ring_o      (ring_o)
    );

    // Each entry is {init, dir, expected ring after the edge}.
    localparam int NV = 13;
    localparam logic [5:0] VEC [NV] = '{
        {1'b1, 1'b1, 4'b1000},  // R1 seed held through an edge
        {1'b0, 1'b1, 4'b0100},  // R5 lap right
        {1'b0, 1'b1, 4'b0010},
        {1'b0, 1'b1, 4'b0001},
        {1'b0, 1'b1, 4'b1000},
        {1'b0, 1'b0, 4'b0001},  // R7 lap left, wrap top to bottom
        {1'b0, 1'b0, 4'b0010},
        {1'b0, 1'b0, 4'b0100},
        {1'b0, 1'b0, 4'b1000},
        {1'b0, 1'b1, 4'b0100},  // R2 then reverse, R3
        {1'b0, 1'b0, 4'b1000},
        {1'b1, 1'b0, 4'b1000},  // R1 force overrides a move
        {1'b0, 1'b0, 4'b0001}   // R3 left from seed
    };

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: ring actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_hot(input string req, input logic [3:0] act);
        n_checks++;
        if ($countones(act) != 1) begin
            n_fails++;
            $display("FAIL %s: ring actual %b expected exactly one set bit", req, act);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        #1 init_i = 1'b1;
        #0.5 check("R1 reset state", ring_o, 4'b1000);
        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            init_i      = VEC[k][5];
            dir_right_i = VEC[k][4];
            @(posedge clk);
            #1;
            check($sformatf("R1/R2/R3/R5/R7 vector %0d", k), ring_o, VEC[k][3:0]);
            if (!VEC[k][5]) check_hot("R6", ring_o);
        end
        // R1: force between edges, no clock edge needed.
        @(negedge clk);
        #0.5 init_i = 1'b1;
        #0.5 check("R1 async force", ring_o, 4'b1000);
        @(posedge clk);
        #1 check("R1 held", ring_o, 4'b1000);
        @(negedge clk);
        init_i = 1'b0;
        dir_right_i = 1'b1;
        @(posedge clk);
        #1 check("R2 first move", ring_o, 4'b0100);
        // R4: direction wiggles between edges do nothing; the value at the edge counts.
        @(negedge clk);
        dir_right_i = 1'b0;
        #0.5 dir_right_i = 1'b1;
        #0.5 check("R4 no change between edges", ring_o, 4'b0100);
        #0.5 dir_right_i = 1'b0;
        @(posedge clk);
        #1 check("R4 edge value used", ring_o, 4'b1000);
        check_hot("R6 after wiggle", ring_o);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule